// File: doc/BRIEF.md
# Edge-Capturing Interrupt Flag Controller

This block collects interrupt requests from a set of external lines and merges them into one request toward a host processor. Every wired line passes through a synchroniser, and the block then watches it for a low-to-high transition. Each transition sets a sticky pending bit. A bit stays set until software acknowledges it, even after the line goes low again.

A second register blocks individual sources. A blocked source still records its pending bit, but that bit does not reach the output. The combined output is high whenever at least one pending bit is not blocked. Software reads the pending bits and the block bits over a small 16-bit register bus. It acknowledges a source by writing the pending register with a zero in that source's position and ones everywhere else. It blocks or unblocks sources with a read-modify-write of the block register.

The parameter `SRC_USED` selects which of the 16 lines are wired. By default only lines 8, 9 and 10 are wired. Pending bits of unwired lines never set.

Top module: `irq_edge_ctrl`

## Requirements
- R1: After reset every pending bit reads 0, the block register (byte offset 0x0A) reads 0xFFFF, and `irq_out` is 0.
- R2: A low-to-high change on a wired `irq_in` line sets its pending bit (byte offset 0x02, bit n for line n). The bit is visible on the third rising clock edge after the change and not before. It stays set after the line returns low.
- R3: A line that stays high, or a high-to-low change, never sets a pending bit.
- R4: A write to offset 0x02 clears each pending bit whose written bit is 0 and leaves unchanged each pending bit whose written bit is 1.
- R5: If a captured edge and a clearing write reach the same pending bit on the same clock edge, the bit ends up set.
- R6: The block register at offset 0x0A is a full 16-bit read/write register. A 1 blocks its source and a 0 enables it.
- R7: `irq_out` is 1 exactly when some pending bit is set and its block bit is 0. It falls right after the clock edge that clears or blocks the last such bit.
- R8: Pending bits of lines that are not wired (a 0 in `SRC_USED`, default 0x0700) always read 0, whatever those inputs do.
- R9: A read of any offset other than 0x02 and 0x0A returns 0x0000. A write to such an offset changes nothing.
- R10: A blocked source still records its edge. Unblocking it later raises `irq_out` without a new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_in | input | 16 | External interrupt lines, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the registers while `bus_sel` is high, else 0 |
| irq_out | output | 1 | Combined interrupt request, active high |

## Verification
The hardest case to reach from the ports is an acknowledge write that lands on the same clock edge as a fresh captured edge for the same source. This needs the synchroniser latency counted exactly. The bench first drops the line and lets the pipeline settle. It then raises the line and issues the clearing write so that the write completes on the third rising edge after the rise. A plain clear with no edge acts as the control case. Random phases change the lines, write the pending and block registers, and compare both registers and `irq_out` against a model built from R2, R4 and R7.

// File: rtl/irq_ctrl_pkg.sv
`timescale 1ns/1ps
package irq_ctrl_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_BLOCK = 4'hA;

  typedef enum logic [1:0] {
    RSEL_NONE  = 2'd0,
    RSEL_PEND  = 2'd1,
    RSEL_BLOCK = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_src_sync.sv
`timescale 1ns/1ps
// Synchronises one asynchronous line and flags its rising edge.
module irq_src_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;
  logic              last_q;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], line_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_nxt;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/irq_bus_dec.sv
`timescale 1ns/1ps
// Decodes a register access into write strobes and a read selector.
module irq_bus_dec
  import irq_ctrl_pkg::*;
(
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_pend,
  output logic              wr_block,
  output reg_sel_e          rd_sel
);
  logic hit_pend;
  logic hit_block;

  always_comb begin
    hit_pend  = bus_sel && (bus_addr == OFS_PEND);
    hit_block = bus_sel && (bus_addr == OFS_BLOCK);
    wr_pend   = hit_pend  && bus_we;
    wr_block  = hit_block && bus_we;
    if (hit_pend && !bus_we)
      rd_sel = RSEL_PEND;
    else if (hit_block && !bus_we)
      rd_sel = RSEL_BLOCK;
    else
      rd_sel = RSEL_NONE;
  end
endmodule

// File: rtl/irq_pend_bank.sv
`timescale 1ns/1ps
// Sticky pending bits: set by edges, cleared by written zeros, set wins.
module irq_pend_bank #(
  parameter int             NUM_SRC  = 16,
  parameter logic [15:0]    SRC_USED = 16'h0700
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] rise,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wr_data,
  output logic [NUM_SRC-1:0] pend_q
);
  localparam logic [NUM_SRC-1:0] USED = SRC_USED[NUM_SRC-1:0];

  logic [NUM_SRC-1:0] keep;
  logic [NUM_SRC-1:0] pend_nxt;
  logic               pend_en;

  always_comb begin
    keep     = wr_en ? wr_data : '1;
    pend_nxt = ((pend_q & keep) | rise) & USED;
    pend_en  = wr_en | (|(rise & USED));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= '0;
    else if (pend_en)
      pend_q <= pend_nxt;
  end
endmodule

// File: rtl/irq_block_reg.sv
`timescale 1ns/1ps
// Per-source block bits; 1 blocks the source.
module irq_block_reg #(
  parameter int          NUM_SRC   = 16,
  parameter logic [15:0] BLOCK_RST = 16'hFFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wr_data,
  output logic [NUM_SRC-1:0] block_q
);
  logic [NUM_SRC-1:0] block_nxt;

  always_comb begin
    block_nxt = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      block_q <= BLOCK_RST[NUM_SRC-1:0];
    else if (wr_en)
      block_q <= block_nxt;
  end
endmodule

// File: rtl/irq_edge_ctrl.sv
`timescale 1ns/1ps
// Top: edge capture, pending and block registers, combined request.
module irq_edge_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int          NUM_SRC     = 16,
  parameter logic [15:0] SRC_USED    = 16'h0700,
  parameter logic [15:0] BLOCK_RST   = 16'hFFFF,
  parameter int          SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               irq_out
);
  logic [NUM_SRC-1:0] rise_vec;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] mask_q;
  logic               wr_pend;
  logic               wr_block;
  reg_sel_e           rd_sel;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irq_src_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (irq_in[i]),
      .rise    (rise_vec[i])
    );
  end

  irq_bus_dec u_dec (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wr_pend  (wr_pend),
    .wr_block (wr_block),
    .rd_sel   (rd_sel)
  );

  irq_pend_bank #(.NUM_SRC(NUM_SRC), .SRC_USED(SRC_USED)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (rise_vec),
    .wr_en   (wr_pend),
    .wr_data (bus_wdata),
    .pend_q  (flag_q)
  );

  irq_block_reg #(.NUM_SRC(NUM_SRC), .BLOCK_RST(BLOCK_RST)) u_block (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_block),
    .wr_data (bus_wdata),
    .block_q (mask_q)
  );

  always_comb begin
    case (rd_sel)
      RSEL_PEND:  bus_rdata = flag_q;
      RSEL_BLOCK: bus_rdata = mask_q;
      default:    bus_rdata = '0;
    endcase
  end

  assign irq_out = |(flag_q & ~mask_q);
endmodule

// File: rtl/irq_edge_ctrl_chk.sv
`timescale 1ns/1ps
module irq_edge_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int          NUM_SRC  = 16,
  parameter logic [15:0] SRC_USED = 16'h0700
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [NUM_SRC-1:0] bus_wdata,
  input logic [NUM_SRC-1:0] bus_rdata,
  input logic               irq_out,
  input logic [NUM_SRC-1:0] flag_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] rise_vec
);
  localparam logic [NUM_SRC-1:0] USED = SRC_USED[NUM_SRC-1:0];

  logic wr_p;
  logic wr_b;
  assign wr_p = bus_sel && bus_we && (bus_addr == OFS_PEND);
  assign wr_b = bus_sel && bus_we && (bus_addr == OFS_BLOCK);

  // R2: without a write, no pending bit ever falls
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_p |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R4: a bit written 0 is clear afterwards unless an edge arrived
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_p |=> ((flag_q & ~$past(bus_wdata) & ~$past(rise_vec) & USED) == '0));

  // R5: a captured edge on a wired source always lands
  assert_edge_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(rise_vec & USED)) == $past(rise_vec & USED)));

  // R6: the block register takes the written word
  assert_block_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_b |=> (mask_q == $past(bus_wdata)));

  // R7: blocking every source silences the output on the next cycle
  assert_all_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && (bus_wdata == '1)) |=> !irq_out);

  // R8: unwired bits read back as zero
  assert_unwired_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == OFS_PEND) |-> ((bus_rdata & ~USED) == '0));

  // R9: unmapped reads return zero
  assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr != OFS_PEND && bus_addr != OFS_BLOCK) |-> (bus_rdata == '0));
endmodule

bind irq_edge_ctrl irq_edge_ctrl_chk #(.NUM_SRC(NUM_SRC), .SRC_USED(SRC_USED)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .flag_q    (flag_q),
  .mask_q    (mask_q),
  .rise_vec  (rise_vec)
);

// File: tb/test_irq_edge_ctrl.sv
`timescale 1ns/1ps
module test_irq_edge_ctrl;
  localparam logic [15:0] USED = 16'h0700;
  localparam logic [3:0]  A_PEND = 4'h2;
  localparam logic [3:0]  A_BLK  = 4'hA;

  logic        clk;
  logic        rst_n;
  logic [15:0] irq_in;
  logic        bus_sel;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] exp_flag;
  logic [15:0] exp_mask;
  logic [15:0] cur_in;
  logic [15:0] rd;

  irq_edge_ctrl i_irq_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] f_after_write(input logic [15:0] old, input logic [15:0] w);
    return old & w;
  endfunction

  function automatic logic [15:0] f_after_lines(input logic [15:0] old, input logic [15:0] prev,
                                                input logic [15:0] now);
    return old | (now & ~prev & USED);
  endfunction

  function automatic logic f_irq(input logic [15:0] fl, input logic [15:0] mk);
    return |(fl & ~mk);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic set_lines(input logic [15:0] v);
    @(negedge clk);
    exp_flag = f_after_lines(exp_flag, cur_in, v);
    irq_in = v;
    cur_in = v;
    repeat (5) @(posedge clk);
  endtask

  task automatic check_all(input string req);
    logic [15:0] d;
    rd_reg(A_PEND, d);
    check({req, " pend"}, d, exp_flag);
    rd_reg(A_BLK, d);
    check({req, " block"}, d, exp_mask);
    check({req, " irq_out"}, {15'd0, irq_out}, {15'd0, f_irq(exp_flag, exp_mask)});
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0101));
    rst_n = 1'b0; irq_in = '0; cur_in = '0;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    exp_flag = '0; exp_mask = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    rd_reg(A_PEND, rd); check("R1 pend", rd, 16'h0000);
    rd_reg(A_BLK, rd);  check("R1 block", rd, 16'hFFFF);
    check("R1 irq_out", {15'd0, irq_out}, 16'd0);

    // R2: latency of three rising edges, then sticky
    @(negedge clk); irq_in = 16'h0200; cur_in = 16'h0200;
    @(posedge clk); @(posedge clk);
    rd_reg(A_PEND, rd); check("R2 not yet after two edges", rd, 16'h0000);
    @(posedge clk);
    rd_reg(A_PEND, rd); check("R2 set on third edge", rd, 16'h0200);
    exp_flag = 16'h0200;
    set_lines(16'h0000);
    rd_reg(A_PEND, rd); check("R2 sticky after line low", rd, 16'h0200);
    // R10: blocked source still latched, output low
    check("R10 blocked no irq", {15'd0, irq_out}, 16'd0);

    // R4 / R3: clear while line steadily high, then falling edge
    set_lines(16'h0200);
    wr_reg(A_PEND, 16'hFDFF); exp_flag = f_after_write(exp_flag, 16'hFDFF);
    rd_reg(A_PEND, rd); check("R4 clear by zero", rd, 16'h0000);
    repeat (5) @(posedge clk);
    rd_reg(A_PEND, rd); check("R3 steady high", rd, 16'h0000);
    set_lines(16'h0000);
    rd_reg(A_PEND, rd); check("R3 falling edge", rd, 16'h0000);

    // R8: all lines rise, only wired ones latch
    set_lines(16'hFFFF);
    rd_reg(A_PEND, rd); check("R8 unwired stay zero", rd, 16'h0700);
    set_lines(16'h0000);

    // R6: block register round trip
    wr_reg(A_BLK, 16'hA5F0); exp_mask = 16'hA5F0;
    rd_reg(A_BLK, rd); check("R6 block readback", rd, 16'hA5F0);
    // R10: unblock 10 only -> output rises without a new edge
    wr_reg(A_BLK, 16'hFBFF); exp_mask = 16'hFBFF;
    @(negedge clk); check("R10 unblock raises irq", {15'd0, irq_out}, 16'd1);
    wr_reg(A_BLK, 16'hFFFF); exp_mask = 16'hFFFF;
    @(negedge clk); check("R7 block all drops irq", {15'd0, irq_out}, 16'd0);

    // R7: clearing last pending bit drops output right after the write edge
    wr_reg(A_BLK, 16'h0000); exp_mask = 16'h0000;
    @(negedge clk); check("R7 irq high", {15'd0, irq_out}, 16'd1);
    wr_reg(A_PEND, 16'hFCFF); exp_flag = f_after_write(exp_flag, 16'hFCFF);
    @(negedge clk); check("R7 irq held by bit 10", {15'd0, irq_out}, 16'd1);
    wr_reg(A_PEND, 16'hFBFF); exp_flag = f_after_write(exp_flag, 16'hFBFF);
    @(negedge clk); check("R7 irq drops after last clear", {15'd0, irq_out}, 16'd0);

    // R5: edge and clearing write on the same clock edge
    set_lines(16'h0100);               // sets bit 8
    set_lines(16'h0000);
    @(negedge clk); irq_in = 16'h0100; cur_in = 16'h0100;
    @(posedge clk); @(posedge clk);
    wr_reg(A_PEND, 16'hFEFF);          // completes on third edge
    rd_reg(A_PEND, rd); check("R5 set wins over clear", rd, 16'h0100);
    wr_reg(A_PEND, 16'hFEFF);
    rd_reg(A_PEND, rd); check("R4 clear without edge", rd, 16'h0000);
    exp_flag = 16'h0000;
    set_lines(16'h0000);

    // R9: unmapped offsets
    set_lines(16'h0400);
    wr_reg(4'h4, 16'h0000);
    wr_reg(4'hC, 16'h0000);
    wr_reg(4'h3, 16'h0000);
    check_all("R9 writes ignored");
    rd_reg(4'h4, rd); check("R9 read 0x4", rd, 16'h0000);
    rd_reg(4'h3, rd); check("R9 read 0x3", rd, 16'h0000);
    rd_reg(4'h0, rd); check("R9 read 0x0", rd, 16'h0000);

    // Random phase: R2 R4 R6 R7 R8
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0: set_lines(16'($urandom));
        1: begin
          logic [15:0] w;
          w = 16'($urandom) | 16'($urandom);
          wr_reg(A_PEND, w);
          exp_flag = f_after_write(exp_flag, w);
        end
        2: begin
          logic [15:0] w;
          w = 16'($urandom);
          wr_reg(A_BLK, w);
          exp_mask = w;
        end
        default: check_all("R7 random");
      endcase
    end
    check_all("R2 R4 R6 R8 random final");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule